// File: doc/BRIEF.md
# Host Bus Power-Mode Controller

This block sits between an asynchronous parallel host bus (active-low chip-enable, write-strobe and read-strobe) and the power domains of a memory device. It keeps track of the device's operating mode and decodes host cycles to a four-entry byte register file. It runs a confirmed two-write command protocol for mode changes, an inactivity timer that drops the device into a clock-gated standby, and a wake-up delay that brings it back from deep power-down. The memory array, the regulators and the oscillator are outside the block and are controlled only through its enable outputs. All timing is counted on a free-running system clock.

The bus strobes, address and write data pass together through a two-flop synchroniser. A host cycle completes on the edge where its strobes are released. The register map is as follows. Address 0 is the mode-control register, and bits [1:0] hold the requested mode: 00 Reset, 01 Normal, 10 Deep Power-Down, 11 no change. Address 1 is the confirmation register. Address 2 is the wake (NOP) register, which always reads 0. Address 3 is a general-purpose scratch byte.

The controller has seven states. BOOT is entered on system reset or while the host reset pin is low. RESET, NORMAL and STANDBY follow. DPD_ARM waits for the bus to go quiet. DPD is deep power-down, and WAKE is the wake delay. The transitions are:
- BOOT→RESET after the wake delay, once the host reset is released.
- RESET→NORMAL, RESET→DPD_ARM, NORMAL→RESET and NORMAL→DPD_ARM on a confirmed command.
- NORMAL→STANDBY on idle timeout.
- STANDBY→NORMAL on any access.
- DPD_ARM→DPD when all strobes are high.
- DPD→WAKE on a NOP write.
- WAKE→NORMAL after the wake delay.
- Any state→BOOT while the host reset is asserted.

Top module: `hbus_pwr_ctl`

## Requirements
- R1: A write takes effect only if chip-enable and write-strobe were low together, and it completes when they are released. A write-strobe pulse with chip-enable high changes no register.
- R2: While chip-enable and read-strobe are both low in RESET, NORMAL or STANDBY, data_oe is 1 and rdata shows the addressed register.
- R3: Writing value V to address 0 and then ~V to address 1 carries out the mode code V[1:0]: 00 goes to RESET, 01 goes to NORMAL, 10 goes to DPD_ARM, and 11 causes no change.
- R4: If the confirmation data is not the complement of V, or any write other than one to address 0 comes between the two writes, the sequence is aborted and the mode is unchanged.
- R5: In RESET, only writes to addresses 0 and 1 are accepted, and every read returns 8'h00.
- R6: After IDLE_CYC consecutive cycles in NORMAL with no access, the block enters STANDBY (mode output 2'b10) and core_clk_en goes low.
- R7: Any access while in STANDBY returns the block to NORMAL (mode output 2'b01).
- R8: A confirmed code 10 enters DPD (mode output 2'b11) once chip-enable, write-strobe and read-strobe are all high. In DPD, core_clk_en and analog_en are 0.
- R9: In DPD, writes to any address other than 2 are ignored, and reads keep data_oe at 0.
- R10: A write to address 2 in DPD starts WAKE. busy_n is 0 for WAKE_CYC cycles, then the block enters NORMAL with busy_n at 1.
- R11: The register contents are the same after a DPD entry and exit as they were before it.
- R12: While rstin_n is low, the block is in BOOT with busy_n at 0 and the registers cleared. After rstin_n is released, it waits WAKE_CYC cycles, then enters RESET (mode output 2'b00) with busy_n at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rst_n | input | 1 | System reset, active low |
| rstin_n | input | 1 | Host reset pin, active low |
| ce_n | input | 1 | Bus chip-enable, active low |
| we_n | input | 1 | Bus write strobe, active low |
| oe_n | input | 1 | Bus read strobe, active low |
| addr | input | ADDR_W | Register address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data |
| data_oe | output | 1 | Data-bus output enable |
| busy_n | output | 1 | Busy indication, active low |
| mode | output | 2 | Current mode: 00 Reset, 01 Normal, 10 Standby, 11 Deep Power-Down |
| core_clk_en | output | 1 | Core clock enable |
| analog_en | output | 1 | Regulator and oscillator enable |

## Verification
The hardest situation to reach is a round trip through deep power-down with a known register image that must survive it. The bench first writes a distinctive scratch value in NORMAL. It then issues the confirmed code 10, checks that the enables are low, and tries a stray scratch write and a read while in DPD. Finally it sends the NOP, checks busy_n partway through the wake delay, and reads both the scratch and control registers back once NORMAL returns. A second hard case is the aborted command: an unrelated write placed between the two halves of a sequence must leave the mode untouched.

// File: rtl/hbus_pkg.sv
package hbus_pkg;

    typedef enum logic [2:0] {
        ST_BOOT,
        ST_RESET,
        ST_NORMAL,
        ST_STANDBY,
        ST_DPD_ARM,
        ST_DPD,
        ST_WAKE
    } hb_state_e;

    // register addresses
    localparam int REG_CTRL    = 0;
    localparam int REG_CONF    = 1;
    localparam int REG_NOP     = 2;
    localparam int REG_SCRATCH = 3;

    // requested-mode codes in control bits [1:0]
    localparam logic [1:0] CMD_RESET  = 2'b00;
    localparam logic [1:0] CMD_NORMAL = 2'b01;
    localparam logic [1:0] CMD_DPD    = 2'b10;

    // mode output codes
    localparam logic [1:0] MODE_RESET   = 2'b00;
    localparam logic [1:0] MODE_NORMAL  = 2'b01;
    localparam logic [1:0] MODE_STANDBY = 2'b10;
    localparam logic [1:0] MODE_DPD     = 2'b11;

endpackage

// File: rtl/hbus_sync.sv
module hbus_sync #(
    parameter int ADDR_W   = 2,
    parameter int DATA_W   = 8,
    parameter int SYNC_STG = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              wr_evt,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              rd_act,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              acc_act,
    output logic              bus_quiet
);
    localparam int BW    = 3 + ADDR_W + DATA_W;
    localparam int OE_B  = DATA_W + ADDR_W;
    localparam int WE_B  = OE_B + 1;
    localparam int CE_B  = OE_B + 2;
    localparam logic [BW-1:0] RST_V = {3'b111, {(ADDR_W + DATA_W){1'b0}}};

    logic [BW-1:0] pipe [0:SYNC_STG];
    logic [BW-1:0] prv;

    assign pipe[0] = {ce_n, we_n, oe_n, addr, wdata};

    for (genvar g = 0; g < SYNC_STG; g++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe[g+1] <= RST_V;
            else        pipe[g+1] <= pipe[g];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prv <= RST_V;
        else        prv <= pipe[SYNC_STG];
    end

    logic [BW-1:0] cur;
    logic          cur_wr, prv_wr;
    assign cur     = pipe[SYNC_STG];
    assign cur_wr  = !cur[CE_B] && !cur[WE_B];
    assign prv_wr  = !prv[CE_B] && !prv[WE_B];

    assign wr_evt    = prv_wr && !cur_wr;
    assign wr_addr   = prv[OE_B-1:DATA_W];
    assign wr_data   = prv[DATA_W-1:0];
    assign rd_act    = !cur[CE_B] && !cur[OE_B];
    assign rd_addr   = cur[OE_B-1:DATA_W];
    assign acc_act   = !cur[CE_B] && (!cur[WE_B] || !cur[OE_B]);
    assign bus_quiet = cur[CE_B] && cur[WE_B] && cur[OE_B];

    // R1
    wr_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_evt |=> !wr_evt);

endmodule

// File: rtl/hbus_cnt.sv
module hbus_cnt #(
    parameter int CYC = 38
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic hit
);
    localparam int CW = $clog2(CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(CYC - 1);

    logic [CW-1:0] cnt;

    assign hit = !clr && (cnt == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt <= '0;
        else if (clr || hit) cnt <= '0;
        else                 cnt <= cnt + 1'b1;
    end

    // R6
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);

endmodule

// File: rtl/hbus_regs.sv
module hbus_regs
    import hbus_pkg::*;
#(
    parameter int ADDR_W = 2,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  hb_state_e         st,
    input  logic              wr_evt,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_val,
    output logic              cmd_go,
    output logic [1:0]        cmd_mode,
    output logic              nop_hit
);
    logic [DATA_W-1:0] ctrl_q, conf_q, scratch_q;
    logic              pend_q;

    logic is_ctrl, is_conf, is_nop, is_scr;
    assign is_ctrl = (wr_addr == ADDR_W'(REG_CTRL));
    assign is_conf = (wr_addr == ADDR_W'(REG_CONF));
    assign is_nop  = (wr_addr == ADDR_W'(REG_NOP));
    assign is_scr  = (wr_addr == ADDR_W'(REG_SCRATCH));

    logic acc_ctrl, acc_conf, acc_scr, acc_nop;
    always_comb begin
        acc_ctrl = 1'b0;
        acc_conf = 1'b0;
        acc_scr  = 1'b0;
        acc_nop  = 1'b0;
        unique case (st)
            ST_NORMAL, ST_STANDBY, ST_DPD_ARM: begin
                acc_ctrl = wr_evt && is_ctrl;
                acc_conf = wr_evt && is_conf;
                acc_scr  = wr_evt && is_scr;
            end
            ST_RESET: begin
                acc_ctrl = wr_evt && is_ctrl;
                acc_conf = wr_evt && is_conf;
            end
            ST_DPD: begin
                acc_nop = wr_evt && is_nop;
            end
            ST_BOOT, ST_WAKE: ;
        endcase
    end

    logic conf_ok;
    assign conf_ok = acc_conf && pend_q && (wr_data == ~ctrl_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q    <= '0;
            conf_q    <= '0;
            scratch_q <= '0;
            pend_q    <= 1'b0;
            cmd_go    <= 1'b0;
            nop_hit   <= 1'b0;
        end else if (clr) begin
            ctrl_q    <= '0;
            conf_q    <= '0;
            scratch_q <= '0;
            pend_q    <= 1'b0;
            cmd_go    <= 1'b0;
            nop_hit   <= 1'b0;
        end else begin
            cmd_go  <= conf_ok;
            nop_hit <= acc_nop;
            if (acc_ctrl) ctrl_q    <= wr_data;
            if (acc_conf) conf_q    <= wr_data;
            if (acc_scr)  scratch_q <= wr_data;
            if (acc_ctrl)          pend_q <= 1'b1;
            else if (wr_evt)       pend_q <= 1'b0;
        end
    end

    assign cmd_mode = ctrl_q[1:0];

    always_comb begin
        if (rd_addr == ADDR_W'(REG_CTRL))      rd_val = ctrl_q;
        else if (rd_addr == ADDR_W'(REG_CONF)) rd_val = conf_q;
        else if (rd_addr == ADDR_W'(REG_SCRATCH)) rd_val = scratch_q;
        else                                   rd_val = '0;
    end

    // R11
    dpd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_DPD && $past(st) == ST_DPD) |-> ($stable(scratch_q) && $stable(ctrl_q)));

    // R3
    go_src_chk: assert property (@(posedge clk) disable iff (!rst_n || clr)
        cmd_go |-> $past(wr_evt && wr_addr == ADDR_W'(REG_CONF)));

endmodule

// File: rtl/hbus_pwr_ctl.sv
module hbus_pwr_ctl
    import hbus_pkg::*;
#(
    parameter int ADDR_W   = 2,
    parameter int DATA_W   = 8,
    parameter int IDLE_CYC = 38,
    parameter int WAKE_CYC = 150
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rstin_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              data_oe,
    output logic              busy_n,
    output logic [1:0]        mode,
    output logic              core_clk_en,
    output logic              analog_en
);
    hb_state_e state_q, state_d;

    // host reset synchroniser
    logic [1:0] rsti_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rsti_q <= 2'b00;
        else        rsti_q <= {rsti_q[0], rstin_n};
    end
    logic rst_act;
    assign rst_act = !rsti_q[1];

    logic              wr_evt, rd_act, acc_act, bus_quiet;
    logic [ADDR_W-1:0] wr_addr, rd_addr;
    logic [DATA_W-1:0] wr_data, rd_val;

    hbus_sync #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SYNC_STG(2)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n), .addr(addr), .wdata(wdata),
        .wr_evt(wr_evt), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_act(rd_act), .rd_addr(rd_addr), .acc_act(acc_act), .bus_quiet(bus_quiet)
    );

    logic       cmd_go, nop_hit;
    logic [1:0] cmd_mode;

    hbus_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .clr(rst_act), .st(state_q),
        .wr_evt(wr_evt), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_val(rd_val),
        .cmd_go(cmd_go), .cmd_mode(cmd_mode), .nop_hit(nop_hit)
    );

    logic idle_clr, idle_hit, wk_clr, wk_hit;
    assign idle_clr = (state_q != ST_NORMAL) || acc_act;
    assign wk_clr   = !(state_q == ST_WAKE || state_q == ST_BOOT) || rst_act;

    hbus_cnt #(.CYC(IDLE_CYC)) u_idle (
        .clk(clk), .rst_n(rst_n), .clr(idle_clr), .hit(idle_hit)
    );

    hbus_cnt #(.CYC(WAKE_CYC)) u_wake (
        .clk(clk), .rst_n(rst_n), .clr(wk_clr), .hit(wk_hit)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_BOOT;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_BOOT:    if (wk_hit) state_d = ST_RESET;
            ST_RESET: begin
                if (cmd_go && cmd_mode == CMD_NORMAL)   state_d = ST_NORMAL;
                else if (cmd_go && cmd_mode == CMD_DPD) state_d = ST_DPD_ARM;
            end
            ST_NORMAL: begin
                if (cmd_go && cmd_mode == CMD_RESET)    state_d = ST_RESET;
                else if (cmd_go && cmd_mode == CMD_DPD) state_d = ST_DPD_ARM;
                else if (idle_hit)                      state_d = ST_STANDBY;
            end
            ST_STANDBY: if (acc_act)   state_d = ST_NORMAL;
            ST_DPD_ARM: if (bus_quiet) state_d = ST_DPD;
            ST_DPD:     if (nop_hit)   state_d = ST_WAKE;
            ST_WAKE:    if (wk_hit)    state_d = ST_NORMAL;
        endcase
        if (rst_act) state_d = ST_BOOT;
    end

    // outputs
    always_comb begin
        mode        = MODE_RESET;
        core_clk_en = 1'b1;
        analog_en   = 1'b1;
        busy_n      = 1'b1;
        data_oe     = 1'b0;
        rdata       = '0;
        unique case (state_q)
            ST_BOOT: begin
                busy_n = 1'b0;
            end
            ST_RESET: begin
                data_oe = rd_act;
            end
            ST_NORMAL, ST_DPD_ARM: begin
                mode    = MODE_NORMAL;
                data_oe = rd_act;
                rdata   = rd_act ? rd_val : '0;
            end
            ST_STANDBY: begin
                mode        = MODE_STANDBY;
                core_clk_en = 1'b0;
                data_oe     = rd_act;
                rdata       = rd_act ? rd_val : '0;
            end
            ST_DPD: begin
                mode        = MODE_DPD;
                core_clk_en = 1'b0;
                analog_en   = 1'b0;
            end
            ST_WAKE: begin
                mode        = MODE_DPD;
                core_clk_en = 1'b0;
                busy_n      = 1'b0;
            end
        endcase
    end

    // R6
    standby_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STANDBY && $past(state_q) == ST_NORMAL) |-> $past(idle_hit));

    // R9
    dpd_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DPD && rd_act) |-> !data_oe);

    // R10
    wake_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAKE && !wk_hit && !rst_act) |=> (state_q == ST_WAKE));

    // R12
    boot_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_act |=> !busy_n);

    // R5
    reset_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RESET && data_oe) |-> (rdata == '0));

endmodule

// File: tb/hbus_pwr_ctl_tb.sv
module hbus_pwr_ctl_tb;
    localparam int AW   = 2;
    localparam int DW   = 8;
    localparam int IDLE = 38;
    localparam int WAKE = 150;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rstin_n = 1'b1;
    logic          ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic          data_oe, busy_n, core_clk_en, analog_en;
    logic [1:0]    mode;

    int total = 0;
    int fails = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    hbus_pwr_ctl #(.ADDR_W(AW), .DATA_W(DW), .IDLE_CYC(IDLE), .WAKE_CYC(WAKE)) u_dut (
        .clk(clk), .rst_n(rst_n), .rstin_n(rstin_n),
        .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n), .addr(addr), .wdata(wdata),
        .rdata(rdata), .data_oe(data_oe), .busy_n(busy_n), .mode(mode),
        .core_clk_en(core_clk_en), .analog_en(analog_en)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        addr = a; wdata = d; ce_n = 1'b0; we_n = 1'b0;
        repeat (3) @(negedge clk);
        ce_n = 1'b1; we_n = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    task automatic bus_rd(input logic [AW-1:0] a, output logic [DW-1:0] d, output logic oe);
        @(negedge clk);
        addr = a; ce_n = 1'b0; oe_n = 1'b0;
        repeat (4) @(negedge clk);
        d = rdata; oe = data_oe;
        ce_n = 1'b1; oe_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic go_normal();
        bus_wr(2'd0, 8'h01);
        bus_wr(2'd1, 8'hFE);
    endtask

    task automatic t_boot();
        @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R12 busy during boot", busy_n, 1'b0);
        repeat (WAKE + 10) @(negedge clk);
        chk("R12 boot ends in reset mode", mode, 2'b00);
        chk("R12 busy released", busy_n, 1'b1);
    endtask

    task automatic t_reset_mode();
        logic [DW-1:0] d; logic oe;
        bus_wr(2'd3, 8'h77);
        bus_rd(2'd3, d, oe);
        chk("R5 read in reset returns zero", d, 8'h00);
        chk("R2 data_oe in reset", oe, 1'b1);
        bus_wr(2'd0, 8'h01);
        bus_wr(2'd1, 8'hFF);
        chk("R4 bad complement keeps reset", mode, 2'b00);
        go_normal();
        chk("R3 confirmed code 01 gives normal", mode, 2'b01);
        bus_rd(2'd3, d, oe);
        chk("R5 scratch write in reset was dropped", d, 8'h00);
    endtask

    task automatic t_normal_rw();
        logic [DW-1:0] d; logic oe;
        bus_wr(2'd3, 8'h3C);
        bus_rd(2'd3, d, oe);
        chk("R2 scratch readback", d, 8'h3C);
        chk("R2 data_oe asserted", oe, 1'b1);
        bus_rd(2'd0, d, oe);
        chk("R2 ctrl readback", d, 8'h01);
        // write strobe with chip-enable high
        @(negedge clk);
        addr = 2'd3; wdata = 8'hC3; we_n = 1'b0;
        repeat (3) @(negedge clk);
        we_n = 1'b1;
        repeat (6) @(negedge clk);
        bus_rd(2'd3, d, oe);
        chk("R1 write without chip-enable ignored", d, 8'h3C);
    endtask

    task automatic t_abort();
        logic [DW-1:0] d; logic oe;
        bus_wr(2'd0, 8'h00);
        bus_wr(2'd3, 8'h99);
        bus_wr(2'd1, 8'hFF);
        chk("R4 interleaved write aborts", mode, 2'b01);
        bus_rd(2'd3, d, oe);
        chk("R4 interleaved write itself landed", d, 8'h99);
        bus_wr(2'd0, 8'h01);
        bus_wr(2'd1, 8'hFE);
    endtask

    task automatic t_standby();
        logic [DW-1:0] d; logic oe;
        repeat (IDLE - 12) @(negedge clk);
        chk("R6 still normal before timeout", mode, 2'b01);
        repeat (20) @(negedge clk);
        chk("R6 standby after idle", mode, 2'b10);
        chk("R6 core clock gated", core_clk_en, 1'b0);
        bus_rd(2'd3, d, oe);
        chk("R7 access wakes to normal", mode, 2'b01);
        chk("R7 read data during wake", d, 8'h99);
    endtask

    task automatic t_dpd();
        logic [DW-1:0] d; logic oe;
        bus_wr(2'd3, 8'hA5);
        bus_wr(2'd0, 8'h02);
        bus_wr(2'd1, 8'hFD);
        chk("R8 dpd mode", mode, 2'b11);
        chk("R8 analog disabled", analog_en, 1'b0);
        chk("R8 core clock off", core_clk_en, 1'b0);
        bus_wr(2'd3, 8'h11);
        bus_rd(2'd3, d, oe);
        chk("R9 no drive in dpd", oe, 1'b0);
        chk("R9 still dpd after access", mode, 2'b11);
        bus_wr(2'd2, 8'h00);
        chk("R10 busy during wake", busy_n, 1'b0);
        repeat (WAKE / 2) @(negedge clk);
        chk("R10 busy mid wake", busy_n, 1'b0);
        repeat (WAKE / 2 + 5) @(negedge clk);
        chk("R10 normal after wake", mode, 2'b01);
        chk("R10 busy released", busy_n, 1'b1);
        bus_rd(2'd3, d, oe);
        chk("R11 scratch retained over dpd", d, 8'hA5);
        bus_rd(2'd0, d, oe);
        chk("R11 ctrl retained over dpd", d, 8'h02);
    endtask

    task automatic t_rstin();
        logic [DW-1:0] d; logic oe;
        @(negedge clk);
        rstin_n = 1'b0;
        repeat (5) @(negedge clk);
        chk("R12 busy while host reset", busy_n, 1'b0);
        chk("R12 reset mode code", mode, 2'b00);
        rstin_n = 1'b1;
        repeat (WAKE / 2) @(negedge clk);
        chk("R12 busy during delay", busy_n, 1'b0);
        repeat (WAKE / 2 + 10) @(negedge clk);
        chk("R12 ready in reset", mode, 2'b00);
        chk("R12 busy negated", busy_n, 1'b1);
        go_normal();
        bus_rd(2'd3, d, oe);
        chk("R12 registers cleared", d, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_boot();
        t_reset_mode();
        t_normal_rw();
        t_abort();
        t_standby();
        t_dpd();
        t_rstin();
        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

endmodule